// File: doc/BRIEF.md
# Heartbeat SQE Test Pulse Generator

After every clean transmission, this block issues the signal-quality-error test burst, also called heartbeat. The block watches a transmit-activity flag. When that flag drops at the end of a frame that saw no collision and no jabber, and heartbeat is enabled, a countdown starts. The countdown runs on a bit-time tick. When it expires, the block raises a request for a fixed number of bit times. That request gates the 10 MHz collision-signal waveform onto the collision pair. When the burst ends the request falls, the pair is idle again and the block goes back to rest.

The delay and the burst length are parameters. By default they are 11 and 10 bit times, and both are measured only in bit-time ticks, never in clock cycles. One down-counter serves both phases. If transmission resumes while a burst is pending or running, the burst is dropped.

Top module: `hb_sqe_gen`

## Requirements
- R1: After reset, sqe_req is low and no burst is pending.
- R2: After a qualifying end of transmission, sqe_req rises in the clock cycle after the DELAY_BT-th bit_tick (default 11) that follows the falling edge of tx_active.
- R3: Once high, sqe_req stays high for exactly BURST_BT bit ticks (default 10). It falls in the cycle after the BURST_BT-th tick counted inside the burst.
- R4: If hb_enable is low in the cycle in which tx_active is first seen low, no burst is produced for that transmission.
- R5: If collision is high in any cycle while tx_active is high, no burst follows that transmission.
- R6: If jabber is high in any cycle while tx_active is high, no burst follows that transmission.
- R7: The fault record is cleared when a new transmission starts, so a clean transmission after a faulty one produces a burst.
- R8: If tx_active rises while the delay is still counting, the pending burst is cancelled and sqe_req never rises for it.
- R9: If tx_active rises during a burst, sqe_req is low from the next cycle on and the burst does not resume.
- R10: Clock cycles without bit_tick do not advance the delay or the burst. The output timing depends only on the number of ticks, whatever the tick spacing.
- R11: Changes of hb_enable after the end of transmission do not affect a burst that is already pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_active | input | 1 | High while the station is transmitting |
| hb_enable | input | 1 | Heartbeat function enable |
| collision | input | 1 | Collision condition present |
| jabber | input | 1 | Jabber condition present |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| sqe_req | output | 1 | Request to gate the collision waveform onto the pair |

## Verification
The bench drives transmissions of random length, with random bit-tick spacing and random gaps, against a bench model that counts ticks since the falling edge.

- Clean frames with long gaps show whether the delay and the burst length are counted in ticks. Changing the tick spacing from one to five cycles separates tick counting from cycle counting.
- Frames with a collision or jabber pulse at the first, a middle or the last active cycle show whether a fault anywhere in the frame suppresses the burst. A clean frame that follows a faulty one shows whether the fault record is cleared at the next frame start.
- Gaps cut short at random points in the wait or in the burst tell a cancel apart from a burst that merely continues.
- Enable held low at the falling edge, and enable toggled during the gap, tell sampling at the end of transmission apart from sampling at any other time.

// File: rtl/hb_sqe_pkg.sv
package hb_sqe_pkg;

  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_BURST = 2'd2
  } hb_state_e;

  // Counter width able to hold the larger of the two reload values.
  function automatic int unsigned hb_cnt_width(input int unsigned delay_bt,
                                               input int unsigned burst_bt);
    int unsigned top;
    top = (delay_bt > burst_bt) ? delay_bt : burst_bt;
    return (top < 2) ? 1 : $clog2(top + 1);
  endfunction

endpackage

// File: rtl/hb_tx_monitor.sv
// Finds the start and end of a transmission and records whether any
// collision or jabber was seen while it was active.
module hb_tx_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic collision,
  input  logic jabber,
  output logic tx_start,
  output logic tx_end,
  output logic fault_q
);

  logic tx_q;
  logic fault_now;

  assign fault_now = collision | jabber;
  assign tx_start  = tx_active & ~tx_q;
  assign tx_end    = tx_q & ~tx_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      tx_q <= tx_active;
      if (tx_start)       fault_q <= fault_now;            // R7: new frame, fresh record
      else if (tx_active) fault_q <= fault_q | fault_now;  // R5, R6
    end
  end

  // R7: the record only holds faults seen while transmitting
  p_fault_fresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !fault_now) |=> !fault_q);

  // R5/R6: a fault seen during activity is not lost before the frame ends
  p_fault_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && fault_now) |=> fault_q);

endmodule

// File: rtl/hb_bit_counter.sv
// Shared down-counter for the delay and burst phases.
module hb_bit_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign last = (cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (load)                    cnt <= load_val;
    else if (dec && (cnt != '0))      cnt <= cnt - ONE;
  end

  // R10: without a load or a decrement, the count holds
  p_cnt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !dec) |=> $stable(cnt));

  // R3: the count never wraps below zero
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !load) |=> (cnt == '0));

endmodule

// File: rtl/hb_sqe_gen.sv
module hb_sqe_gen #(
  parameter int unsigned DELAY_BT = 11,
  parameter int unsigned BURST_BT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic hb_enable,
  input  logic collision,
  input  logic jabber,
  input  logic bit_tick,
  output logic sqe_req
);
  import hb_sqe_pkg::*;

  localparam int unsigned CNT_W = hb_cnt_width(DELAY_BT, BURST_BT);
  localparam logic [CNT_W-1:0] DELAY_LD = CNT_W'(DELAY_BT);
  localparam logic [CNT_W-1:0] BURST_LD = CNT_W'(BURST_BT);

  hb_state_e        state_q, state_d;
  logic             tx_start, tx_end, fault_q;
  logic             tx_end_clean;
  logic             arm_evt, to_burst_evt, done_evt, cancel_evt;
  logic             cnt_load, cnt_dec, cnt_last;
  logic [CNT_W-1:0] cnt, cnt_load_val;

  hb_tx_monitor u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_active (tx_active),
    .collision (collision),
    .jabber    (jabber),
    .tx_start  (tx_start),
    .tx_end    (tx_end),
    .fault_q   (fault_q)
  );

  hb_bit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .dec      (cnt_dec),
    .cnt      (cnt),
    .last     (cnt_last)
  );

  // Named internal events
  assign tx_end_clean = tx_end & ~fault_q;
  assign arm_evt      = (state_q == HB_IDLE) & tx_end_clean & hb_enable;
  assign cancel_evt   = (state_q != HB_IDLE) & tx_active;
  assign to_burst_evt = (state_q == HB_WAIT)  & ~tx_active & bit_tick & cnt_last;
  assign done_evt     = (state_q == HB_BURST) & ~tx_active & bit_tick & cnt_last;

  assign cnt_load     = arm_evt | to_burst_evt;
  assign cnt_load_val = arm_evt ? DELAY_LD : BURST_LD;
  assign cnt_dec      = bit_tick & ~tx_active & (state_q != HB_IDLE) & ~cnt_load;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HB_IDLE:  if (arm_evt)          state_d = HB_WAIT;
      HB_WAIT:  if (cancel_evt)       state_d = HB_IDLE;
                else if (to_burst_evt) state_d = HB_BURST;
      HB_BURST: if (cancel_evt || done_evt) state_d = HB_IDLE;
      default:  state_d = HB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HB_IDLE;
    else        state_q <= state_d;
  end

  assign sqe_req = (state_q == HB_BURST);

  // R8/R9: transmit activity forces the request low on the next cycle
  p_tx_kills_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |=> !sqe_req);

  // R2/R10: the burst only begins on a bit tick
  p_rise_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sqe_req) |-> $past(bit_tick));

  // R3: the burst only ends on a tick or through a cancel
  p_fall_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sqe_req) |-> ($past(bit_tick) || $past(tx_active)));

  // R4/R5/R6: arming only follows a clean, enabled end of transmission
  p_arm_qualified_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HB_WAIT && $past(state_q) == HB_IDLE)
      |-> ($past(hb_enable) && $past(tx_end) && !$past(fault_q)));

  // R2: a burst is always preceded by the wait phase
  p_burst_after_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sqe_req) |-> ($past(state_q) == HB_WAIT));

endmodule

// File: tb/hb_sqe_gen_test.sv
module hb_sqe_gen_test;

  localparam int unsigned D = 11;
  localparam int unsigned B = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_active = 1'b0;
  logic hb_enable = 1'b0;
  logic collision = 1'b0;
  logic jabber = 1'b0;
  logic bit_tick = 1'b0;
  logic sqe_req;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";
  int tick_per = 1;
  int cyc = 0;
  bit done = 1'b0;

  // bench model state
  bit m_armed = 0;
  int m_k = 0;
  bit m_prev = 0;
  bit m_fault = 0;
  bit m_exp = 0;

  hb_sqe_gen #(.DELAY_BT(D), .BURST_BT(B)) uut (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .hb_enable(hb_enable),
    .collision(collision), .jabber(jabber), .bit_tick(bit_tick), .sqe_req(sqe_req)
  );

  always #5 clk = ~clk;

  // Expected output is on after the D-th tick since the clean end, and
  // stays on for B ticks.
  function automatic bit exp_out(input bit armed, input int k);
    return armed && (k >= D) && (k < D + B);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_armed = 0; m_k = 0; m_prev = 0; m_fault = 0; m_exp = 0;
    end else begin
      if (m_armed) begin
        if (tx_active) m_armed = 0;
        else if (bit_tick) begin
          m_k++;
          if (m_k >= D + B) m_armed = 0;
        end
      end else if (m_prev && !tx_active && !m_fault && hb_enable) begin
        m_armed = 1; m_k = 0;
      end
      if (tx_active && !m_prev) m_fault = collision | jabber;
      else if (tx_active)       m_fault = m_fault | collision | jabber;
      m_prev = tx_active;
      m_exp = exp_out(m_armed, m_k);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (sqe_req !== m_exp) begin
        errors++;
        $display("FAIL %s: sqe_req=%0b expected %0b at cycle %0d", cur_tag, sqe_req, m_exp, cyc);
      end
    end
  end

  task automatic step(input bit tx, input bit col, input bit jab, input bit en);
    @(negedge clk);
    cyc++;
    tx_active = tx; collision = col; jabber = jab; hb_enable = en;
    bit_tick = (cyc % tick_per) == 0;
  endtask

  // fkind: 0 none, 1 collision, 2 jabber; fpos < 0 means no fault
  task automatic frame(input int len, input int fkind, input int fpos,
                       input bit en_end, input int gap, input bit toggle_en);
    for (int i = 0; i < len; i++)
      step(1'b1, (fkind == 1) && (i == fpos), (fkind == 2) && (i == fpos), 1'b1);
    for (int i = 0; i < gap; i++)
      step(1'b0, 1'b0, 1'b0, (i == 0) ? en_end : (toggle_en ? i[0] : en_end));
  endtask

  int seen_high;

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED);
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (sqe_req !== 1'b0) begin
      errors++;
      $display("FAIL R1: sqe_req=%0b expected 0 in reset", sqe_req);
    end
    rst_n = 1'b1;
    step(0, 0, 0, 0);

    // R2, R3: clean frame, ticks every cycle
    cur_tag = "R2/R3"; tick_per = 1;
    seen_high = 0;
    frame(6, 0, -1, 1, 40, 0);
    // R10: tick every 5 cycles
    cur_tag = "R10"; tick_per = 5;
    frame(4, 0, -1, 1, 5 * (D + B + 3), 0);
    tick_per = 1;
    // R4: enable low at the end
    cur_tag = "R4"; frame(5, 0, -1, 0, 40, 0);
    // R5: collision at first, middle, last cycle
    cur_tag = "R5";
    frame(6, 1, 0, 1, 40, 0);
    frame(6, 1, 3, 1, 40, 0);
    frame(6, 1, 5, 1, 40, 0);
    // R6: jabber
    cur_tag = "R6";
    frame(6, 2, 2, 1, 40, 0);
    frame(6, 2, 5, 1, 40, 0);
    // R7: clean frame after faulty one
    cur_tag = "R7"; frame(6, 0, -1, 1, 40, 0);
    // R8: restart during wait
    cur_tag = "R8"; frame(5, 0, -1, 1, 5, 0); frame(3, 0, -1, 0, 40, 0);
    // R9: restart during burst
    cur_tag = "R9"; frame(5, 0, -1, 1, D + 4, 0); frame(3, 0, -1, 0, 40, 0);
    // R11: enable toggles during the gap
    cur_tag = "R11"; frame(5, 0, -1, 1, 40, 1);

    // random mix
    cur_tag = "R2/R3/R5/R6/R8/R9/R10 random";
    for (int n = 0; n < 400; n++) begin
      int fk;
      tick_per = 1 + ($urandom % 4);
      fk = ($urandom % 4 == 0) ? (1 + ($urandom % 2)) : 0;
      frame(1 + ($urandom % 12), fk, $urandom % 12, ($urandom % 5) != 0,
            1 + ($urandom % (tick_per * (D + B + 4))), ($urandom % 3) == 0);
    end
    tick_per = 1;
    frame(3, 0, -1, 0, 5, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule